// File: doc/BRIEF.md
# Two-Wire Programming Port Host Sequencer

This block is the host end of a two-wire serial programming link: one clock wire and one shared, bidirectional data wire. A single request carries a 6-bit command code, a 14-bit write word and two flags. The first flag says whether a data frame follows the command. The second says whether that frame is read from the target or written to it. The sequencer produces the serial clock and shifts out the command. It then keeps the clock low for an enforced gap. After that it runs a 16-pulse data frame, either driving the payload or sampling what the target returns. A second enforced gap completes the request.

Timing comes from two parameters counted in system-clock cycles: the length of one serial-clock half period, and the minimum idle gap (1 µs in the target's terms). The host releases the data wire before any read frame, so host and target never drive it at the same time. A read returns its 14-bit word with a single-cycle valid strobe. A `busy` output tells the requester when the next request may be offered.

Top module: `prog_host_seq`

## Requirements
- R1: A command is sent as 6 serial-clock pulses, bit 0 of the command first. The data wire changes only while the serial clock rises, so each bit is stable at its falling edge.
- R2: A write data frame is 16 pulses. Pulse 1 and pulse 16 carry 0. Pulses 2 to 15 carry write-word bits 0 to 13 in that order.
- R3: Between the last falling edge of a command and the first rising edge of its data frame, the serial clock stays low for exactly HALF_CYC + GAP_CYC system cycles.
- R4: After the last falling edge of a request, `busy` stays high for a trailing gap. The next command's first rising edge therefore comes at least GAP_CYC low cycles after it.
- R5: For a read, `sdata_oe` is 0 from the end of the command through the data frame and the trailing gap. The bits the target presents on pulses 2 to 15 are returned on `rsp_rdata`, the bit from pulse 2 in bit 0.
- R6: `rsp_valid` is a single-cycle pulse, given exactly once per read request and never for writes or for commands without data.
- R7: The serial clock idles low. Each pulse is HALF_CYC cycles high followed by HALF_CYC cycles low.
- R8: A request is taken only while `busy` is low; `req_valid` while busy has no effect. `busy` lasts 12·HALF_CYC + GAP_CYC cycles for a command alone and 44·HALF_CYC + 2·GAP_CYC cycles with a data frame.
- R9: After reset `busy`, `sclk`, `sdata_out` and `rsp_valid` are 0 and `sdata_oe` is 1.
- R10: A request with `req_has_data` low produces only the 6 command pulses and no data frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_cmd | input | 6 | Command code, sent bit 0 first |
| req_wdata | input | 14 | Payload for a write frame |
| req_has_data | input | 1 | 1: a data frame follows the command |
| req_is_read | input | 1 | 1: the data frame is read from the target |
| busy | output | 1 | High from acceptance until the trailing gap ends |
| rsp_valid | output | 1 | One-cycle strobe for a completed read |
| rsp_rdata | output | 14 | Read word, valid with `rsp_valid` |
| sclk | output | 1 | Serial clock to the target |
| sdata_out | output | 1 | Host value for the data wire |
| sdata_oe | output | 1 | 1: host drives the data wire |
| sdata_in | input | 1 | Value seen on the data wire |

## Verification
The embedded assertions watch, on every cycle, that the clock is low whenever the sequencer is idle and that the data wire never changes while the clock is high. They also check that the host releases the wire throughout a read frame, that the response strobe lasts one cycle and follows only reads, and that every command or frame begins after a full gap of low clock. Only the directed scenarios can show the actual bit order on the wire, the exact gap and busy lengths, the returned read word matching what a modelled target presented, and a request made while busy leaving no trace on the wire.

// File: rtl/psq_pkg.sv
package psq_pkg;

    localparam int CMD_BITS   = 6;
    localparam int WORD_BITS  = 14;
    localparam int FRAME_BITS = WORD_BITS + 2;
    localparam int BIT_W      = $clog2(FRAME_BITS);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD_HI,
        ST_CMD_LO,
        ST_GAP_MID,
        ST_DAT_HI,
        ST_DAT_LO,
        ST_GAP_END
    } psq_state_e;

endpackage

// File: rtl/psq_phase_timer.sv
module psq_phase_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic          done_o
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done_o = (cnt_q == '0);

    // A finished phase stays finished until it is reloaded
    AST_TIMER_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q == '0) |=> (cnt_q == '0)); // R7

endmodule

// File: rtl/psq_frame_pack.sv
module psq_frame_pack #(
    parameter int WORD_W = 14,
    localparam int FW    = WORD_W + 2
) (
    input  logic [WORD_W-1:0] word_i,
    output logic [FW-1:0]     frame_o
);

    for (genvar k = 0; k < FW; k++) begin : g_bit
        if (k == 0 || k == FW - 1) begin : g_mark
            assign frame_o[k] = 1'b0;
        end else begin : g_pay
            assign frame_o[k] = word_i[k-1];
        end
    end

endmodule

// File: rtl/prog_host_seq.sv
module prog_host_seq
    import psq_pkg::*;
#(
    parameter int HALF_CYC = 4,
    parameter int GAP_CYC  = 250
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [CMD_BITS-1:0]  req_cmd,
    input  logic [WORD_BITS-1:0] req_wdata,
    input  logic                 req_has_data,
    input  logic                 req_is_read,
    output logic                 busy,
    output logic                 rsp_valid,
    output logic [WORD_BITS-1:0] rsp_rdata,
    output logic                 sclk,
    output logic                 sdata_out,
    output logic                 sdata_oe,
    input  logic                 sdata_in
);

    localparam int MAXC = (GAP_CYC > HALF_CYC) ? GAP_CYC : HALF_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0]    HALF_LD   = CW'(HALF_CYC - 1);
    localparam logic [CW-1:0]    GAP_LD    = CW'(GAP_CYC - 1);
    localparam logic [CW-1:0]    GAP_SAT   = CW'(GAP_CYC);
    localparam logic [BIT_W-1:0] CMD_LAST  = BIT_W'(CMD_BITS - 1);
    localparam logic [BIT_W-1:0] FRM_LAST  = BIT_W'(FRAME_BITS - 1);
    localparam logic [BIT_W-1:0] PAY_FIRST = BIT_W'(1);
    localparam logic [BIT_W-1:0] PAY_LAST  = BIT_W'(FRAME_BITS - 2);

    typedef struct packed {
        psq_state_e           st;
        logic [BIT_W-1:0]     bit_idx;
        logic [CMD_BITS-1:0]  cmd;
        logic [WORD_BITS-1:0] wdata;
        logic                 has_data;
        logic                 is_read;
        logic                 sclk;
        logic                 sdo;
        logic                 oe;
        logic [WORD_BITS-1:0] rd;
        logic                 rsp_v;
    } seq_regs_t;

    localparam seq_regs_t REGS_RST = '{
        st:       ST_IDLE,
        bit_idx:  '0,
        cmd:      '0,
        wdata:    '0,
        has_data: 1'b0,
        is_read:  1'b0,
        sclk:     1'b0,
        sdo:      1'b0,
        oe:       1'b1,
        rd:       '0,
        rsp_v:    1'b0
    };

    seq_regs_t r_d, r_q;

    logic                  tmr_load;
    logic [CW-1:0]         tmr_val;
    logic                  tmr_done;
    logic [FRAME_BITS-1:0] tx_frame;
    logic [CMD_BITS-1:0]   cmd_shift;
    logic [FRAME_BITS-1:0] frm_shift;
    logic [BIT_W-1:0]      bit_next;

    psq_frame_pack #(
        .WORD_W (WORD_BITS)
    ) u_pack (
        .word_i  (r_q.wdata),
        .frame_o (tx_frame)
    );

    psq_phase_timer #(
        .CW (CW)
    ) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .done_o     (tmr_done)
    );

    assign bit_next  = r_q.bit_idx + 1'b1;
    assign cmd_shift = r_q.cmd >> bit_next;
    assign frm_shift = tx_frame >> bit_next;

    always_comb begin
        r_d       = r_q;
        r_d.rsp_v = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = HALF_LD;

        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.cmd      = req_cmd;
                    r_d.wdata    = req_wdata;
                    r_d.has_data = req_has_data;
                    r_d.is_read  = req_has_data & req_is_read;
                    r_d.st       = ST_CMD_HI;
                    r_d.bit_idx  = '0;
                    r_d.sclk     = 1'b1;
                    r_d.sdo      = req_cmd[0];
                    r_d.oe       = 1'b1;
                    tmr_load     = 1'b1;
                    tmr_val      = HALF_LD;
                end
            end

            ST_CMD_HI: begin
                if (tmr_done) begin
                    r_d.st   = ST_CMD_LO;
                    r_d.sclk = 1'b0;
                    tmr_load = 1'b1;
                    tmr_val  = HALF_LD;
                end
            end

            ST_CMD_LO: begin
                if (tmr_done) begin
                    tmr_load = 1'b1;
                    if (r_q.bit_idx == CMD_LAST) begin
                        r_d.st  = r_q.has_data ? ST_GAP_MID : ST_GAP_END;
                        r_d.sdo = 1'b0;
                        r_d.oe  = ~r_q.is_read;
                        tmr_val = GAP_LD;
                    end else begin
                        r_d.st      = ST_CMD_HI;
                        r_d.bit_idx = bit_next;
                        r_d.sclk    = 1'b1;
                        r_d.sdo     = cmd_shift[0];
                        tmr_val     = HALF_LD;
                    end
                end
            end

            ST_GAP_MID: begin
                if (tmr_done) begin
                    r_d.st      = ST_DAT_HI;
                    r_d.bit_idx = '0;
                    r_d.sclk    = 1'b1;
                    r_d.sdo     = r_q.is_read ? 1'b0 : tx_frame[0];
                    tmr_load    = 1'b1;
                    tmr_val     = HALF_LD;
                end
            end

            ST_DAT_HI: begin
                if (tmr_done) begin
                    if (r_q.is_read && r_q.bit_idx >= PAY_FIRST && r_q.bit_idx <= PAY_LAST) begin
                        r_d.rd = {sdata_in, r_q.rd[WORD_BITS-1:1]};
                    end
                    r_d.st   = ST_DAT_LO;
                    r_d.sclk = 1'b0;
                    tmr_load = 1'b1;
                    tmr_val  = HALF_LD;
                end
            end

            ST_DAT_LO: begin
                if (tmr_done) begin
                    tmr_load = 1'b1;
                    if (r_q.bit_idx == FRM_LAST) begin
                        r_d.st    = ST_GAP_END;
                        r_d.sdo   = 1'b0;
                        r_d.rsp_v = r_q.is_read;
                        tmr_val   = GAP_LD;
                    end else begin
                        r_d.st      = ST_DAT_HI;
                        r_d.bit_idx = bit_next;
                        r_d.sclk    = 1'b1;
                        r_d.sdo     = r_q.is_read ? 1'b0 : frm_shift[0];
                        tmr_val     = HALF_LD;
                    end
                end
            end

            ST_GAP_END: begin
                if (tmr_done) begin
                    r_d.st  = ST_IDLE;
                    r_d.sdo = 1'b0;
                    r_d.oe  = 1'b1;
                end
            end

            default: begin
                r_d = REGS_RST;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= REGS_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.st != ST_IDLE);
    assign rsp_valid = r_q.rsp_v;
    assign rsp_rdata = r_q.rd;
    assign sclk      = r_q.sclk;
    assign sdata_out = r_q.sdo;
    assign sdata_oe  = r_q.oe;

    // Run length of low serial clock, saturating at the gap length
    logic [CW-1:0] low_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run_q <= GAP_SAT;
        end else if (r_q.sclk) begin
            low_run_q <= '0;
        end else if (low_run_q != GAP_SAT) begin
            low_run_q <= low_run_q + 1'b1;
        end
    end

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk); // R7

    AST_SDO_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(sdata_out)); // R1

    AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.is_read && (r_q.st == ST_DAT_HI || r_q.st == ST_DAT_LO)) |-> !sdata_oe); // R5

    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R6

    AST_RSP_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (r_q.is_read && r_q.st == ST_GAP_END)); // R6

    AST_FRAME_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sclk) && r_q.bit_idx == '0) |-> (low_run_q >= GAP_SAT)); // R3

    AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid)); // R8

endmodule

// File: tb/test_prog_host_seq.sv
module test_prog_host_seq;

    localparam int H = 3;
    localparam int G = 250;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [5:0]  req_cmd = '0;
    logic [13:0] req_wdata = '0;
    logic        req_has_data = 1'b0;
    logic        req_is_read = 1'b0;
    logic        busy;
    logic        rsp_valid;
    logic [13:0] rsp_rdata;
    logic        sclk;
    logic        sdata_out;
    logic        sdata_oe;
    logic        sdata_in = 1'b0;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    prog_host_seq #(
        .HALF_CYC (H),
        .GAP_CYC  (G)
    ) i_prog_host_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_cmd      (req_cmd),
        .req_wdata    (req_wdata),
        .req_has_data (req_has_data),
        .req_is_read  (req_is_read),
        .busy         (busy),
        .rsp_valid    (rsp_valid),
        .rsp_rdata    (rsp_rdata),
        .sclk         (sclk),
        .sdata_out    (sdata_out),
        .sdata_oe     (sdata_oe),
        .sdata_in     (sdata_in)
    );

    // Wire monitor and target model
    logic        log_bit [0:63];
    logic        log_oe  [0:63];
    int          rise_low [0:63];
    int          rise_n = 0;
    int          fall_n = 0;
    int          lowrun = 0;
    int          rsp_cnt = 0;
    int          busy_cycles = 0;
    logic [13:0] rsp_word = '0;
    logic [13:0] tgt_word = '0;
    logic        prev_sclk = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) busy_cycles++;
            if (rsp_valid) begin
                rsp_cnt++;
                rsp_word = rsp_rdata;
            end
            if (!prev_sclk && sclk) begin
                if (rise_n < 64) rise_low[rise_n] = lowrun;
                rise_n++;
                sdata_in = (rise_n >= 8 && rise_n <= 21) ? tgt_word[rise_n-8] : 1'b0;
                lowrun = 0;
            end else if (!sclk) begin
                lowrun++;
            end
            if (prev_sclk && !sclk) begin
                if (fall_n < 64) begin
                    log_bit[fall_n] = sdata_out;
                    log_oe[fall_n]  = sdata_oe;
                end
                fall_n++;
            end
            prev_sclk = sclk;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic clear_log();
        rise_n      = 0;
        fall_n      = 0;
        rsp_cnt     = 0;
        busy_cycles = 0;
    endtask

    task automatic issue(input logic [5:0] c, input logic [13:0] w, input bit has, input bit rd);
        @(negedge clk);
        req_cmd      = c;
        req_wdata    = w;
        req_has_data = has;
        req_is_read  = rd;
        req_valid    = 1'b1;
        @(negedge clk);
        req_valid    = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic check_cmd_bits(input logic [5:0] c);
        for (int i = 0; i < 6; i++) begin
            check(log_bit[i] === c[i] && log_oe[i] === 1'b1, "R1 command bit", int'(log_bit[i]), int'(c[i]));
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(busy === 1'b0, "R9 busy after reset", int'(busy), 0);
        check(sclk === 1'b0, "R9 sclk after reset", int'(sclk), 0);
        check(sdata_out === 1'b0, "R9 sdata_out after reset", int'(sdata_out), 0);
        check(sdata_oe === 1'b1, "R9 sdata_oe after reset", int'(sdata_oe), 1);
        check(rsp_valid === 1'b0, "R9 rsp_valid after reset", int'(rsp_valid), 0);
    endtask

    task automatic t_cmd_only(input logic [5:0] c);
        clear_log();
        issue(c, 14'h3FFF, 1'b0, 1'b0);
        wait_idle();
        check(fall_n == 6, "R10 pulses without data", fall_n, 6);
        check_cmd_bits(c);
        check(busy_cycles == 12*H + G, "R8 busy length command only", busy_cycles, 12*H + G);
        check(rsp_cnt == 0, "R6 no strobe without read", rsp_cnt, 0);
    endtask

    task automatic t_write(input logic [5:0] c, input logic [13:0] w);
        clear_log();
        issue(c, w, 1'b1, 1'b0);
        wait_idle();
        check(fall_n == 22, "R2 pulses with write frame", fall_n, 22);
        check_cmd_bits(c);
        check(log_bit[6] === 1'b0, "R2 start bit", int'(log_bit[6]), 0);
        check(log_bit[21] === 1'b0, "R2 stop bit", int'(log_bit[21]), 0);
        for (int i = 0; i < 14; i++) begin
            check(log_bit[7+i] === w[i] && log_oe[7+i] === 1'b1, "R2 payload bit", int'(log_bit[7+i]), int'(w[i]));
        end
        for (int i = 1; i < 6; i++) begin
            check(rise_low[i] == H, "R7 low half period", rise_low[i], H);
        end
        check(rise_low[6] == H + G, "R3 command to data gap", rise_low[6], H + G);
        check(busy_cycles == 44*H + 2*G, "R4 busy length with frame", busy_cycles, 44*H + 2*G);
        check(rsp_cnt == 0, "R6 no strobe on write", rsp_cnt, 0);
    endtask

    task automatic t_read(input logic [5:0] c, input logic [13:0] w);
        clear_log();
        tgt_word = w;
        issue(c, 14'h2AAA, 1'b1, 1'b1);
        wait_idle();
        check(fall_n == 22, "R5 pulses with read frame", fall_n, 22);
        check_cmd_bits(c);
        for (int i = 6; i < 22; i++) begin
            check(log_oe[i] === 1'b0, "R5 host released during read", int'(log_oe[i]), 0);
        end
        check(rise_low[6] == H + G, "R3 gap before read frame", rise_low[6], H + G);
        check(rsp_cnt == 1, "R6 single read strobe", rsp_cnt, 1);
        check(rsp_word === w, "R5 read word", int'(rsp_word), int'(w));
        check(busy_cycles == 44*H + 2*G, "R8 busy length read", busy_cycles, 44*H + 2*G);
    endtask

    task automatic t_busy_ignore();
        clear_log();
        issue(6'h06, 14'h0, 1'b0, 1'b0);
        repeat (10) @(negedge clk);
        req_cmd      = 6'h39;
        req_has_data = 1'b1;
        req_is_read  = 1'b1;
        req_valid    = 1'b1;
        repeat (3) @(negedge clk);
        req_valid    = 1'b0;
        wait_idle();
        check(fall_n == 6, "R8 request while busy ignored", fall_n, 6);
        check_cmd_bits(6'h06);
        check(busy_cycles == 12*H + G, "R8 busy unchanged by ignored request", busy_cycles, 12*H + G);
        check(rsp_cnt == 0, "R6 no strobe from ignored request", rsp_cnt, 0);
    endtask

    task automatic t_back_to_back();
        clear_log();
        issue(6'h02, 14'h0001, 1'b1, 1'b0);
        while (busy) @(negedge clk);
        clear_log();
        issue(6'h08, 14'h0, 1'b0, 1'b0);
        wait_idle();
        check(rise_low[0] >= H + G, "R4 gap before next command", rise_low[0], H + G);
        check_cmd_bits(6'h08);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cmd_only(6'b100110);
        t_cmd_only(6'b011001);
        t_write(6'h02, 14'h2A5C);
        t_write(6'h03, 14'h0001);
        t_write(6'h02, 14'h3FFF);
        t_read(6'h04, 14'h1B3E);
        t_read(6'h05, 14'h2001);
        t_busy_ignore();
        t_back_to_back();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule